// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit CPU core. It holds one pending flag for each interrupt source. A pulse on a source input sets that source's flag. Each flag is masked by the source's own enable bit and by a global enable bit. The unmasked flags then compete across four priority levels. The controller keeps a small stack of the priority levels now being serviced, so a handler can be preempted only by a strictly more urgent source. A branch is granted only when the CPU reports that an instruction has completed. The grant is a one-cycle strobe that carries the vector address, which is the base value plus eight times the source index.

Software reads and writes the enables, the priorities and the pending flags through a plain register port: a single-cycle write strobe, and a read that answers combinationally. The CPU reports three things on plain control pins. It strobes every instruction boundary. It flags whether the next instruction is multi-cycle. It strobes the completion of a return-from-interrupt, and that strobe always coincides with a boundary. No pin carries streamed data, so no pin needs a valid/ready handshake. Every control pin acts in the cycle it is high.

A parameter lists the sources whose flag is cleared by hardware when their vector is granted. Software clears every other flag itself before it returns.

Top module: `prio_vec_intc`

## Requirements
- R1: A synchronous active-high reset clears every pending flag, every enable bit (including the global bit), every priority field and the in-service stack. After reset every register reads 0 and no grant is issued.
- R2: A one-cycle high on `src_i[k]` sets pending flag k whether or not source k is enabled. Flag k reads back in register 2 at bit k for k < 8, and in register 3 at bit k-8 for higher k.
- R3: A pending source whose enable bit is 0 is never granted, and it does not stop a lower-ranked enabled source from winning. The enable bits live in register 0 at bit k for k < 7, and in register 1 at bit k-7 for higher k.
- R4: While the global enable (register 0, bit 7) is 0, no grant is issued, whatever the individual enable bits say.
- R5: A grant is evaluated only in a cycle with `insn_done_i` high. `take_o` is high for exactly the following cycle, with `vec_o` = VEC_BASE + 8 × index. No grant occurs in any other cycle.
- R6: Each source has a 2-bit priority field in register 4 + k/4, at bits 2·(k mod 4) and 2·(k mod 4)+1, where 3 is the most urgent level. The highest enabled level wins, and among equal levels the lowest source index wins.
- R7: Each grant pushes the winner's level onto the in-service stack. A new grant needs a level strictly above the top of the stack, or an empty stack. Each `ret_i` pops one level.
- R8: On a grant, the winner's flag is cleared only when that source's bit in AUTO_CLR is 1. The flags of all other sources stay set.
- R9: A boundary that coincides with `ret_i` never grants. A flag still pending and enabled after the return is granted at the next boundary.
- R10: Clearing an enable bit takes effect one cycle late. At a boundary in the cycle right after the clearing write, the source is still granted when `next_multi_i` is 0 and is suppressed when `next_multi_i` is 1.
- R11: A source pulse wins over a pending clear in the same cycle, whether the clear comes from a software write to the pending register or from a hardware clear on grant.
- R12: Register writes take effect at the write edge and read back unchanged through `rd_addr_i`/`rd_data_o`. Unused bit positions read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Per-source trigger pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| insn_done_i | input | 1 | Instruction-boundary strobe from the CPU |
| next_multi_i | input | 1 | Next instruction takes more than one cycle |
| ret_i | input | 1 | Return-from-interrupt completes this cycle |
| take_o | output | 1 | One-cycle vector grant strobe |
| vec_o | output | VEC_W | Vector address, valid with `take_o` |

## Verification
A source pulse can fall in the same cycle as a clear of that same flag. The clear comes either from a software write of 0 to the pending register or from the hardware clear that a grant performs for an auto-cleared source. The bench drives both cases directly, by raising the pulse together with the write strobe and by raising it together with a granting boundary. It then judges the result by reading the pending register, which must still show the flag set. A second pair also shares a cycle: the return strobe and a boundary. That cycle must not grant, and the bench requires the grant one boundary later.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int LVL_W = 2;
  localparam int N_LVL = 4;
  localparam int GLOBAL_BIT = 7;
  typedef logic [LVL_W-1:0] lvl_t;

  function automatic int en_addr(int k);  return (k < 7) ? 0 : 1;            endfunction
  function automatic int en_bit(int k);   return (k < 7) ? k : k - 7;        endfunction
  function automatic int pd_addr(int k);  return (k < 8) ? 2 : 3;            endfunction
  function automatic int pd_bit(int k);   return k % 8;                      endfunction
  function automatic int pr_addr(int k);  return 4 + k / 4;                  endfunction
  function automatic int pr_bit(int k);   return 2 * (k % 4);                endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter logic [N_SRC-1:0] AUTO_CLR = '0,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       rd_addr,
  input  logic             hw_clr,
  input  logic [IDX_W-1:0] hw_idx,
  output logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] en,
  output logic             glob,
  output lvl_t             pri [N_SRC],
  output logic [7:0]       rd_data
);
  always_ff @(posedge clk) begin
    if (rst) glob <= 1'b0;
    else if (wr_en && wr_addr == 3'd0) glob <= wr_data[GLOBAL_BIT];
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    localparam int EA = en_addr(k);
    localparam int EB = en_bit(k);
    localparam int PA = pd_addr(k);
    localparam int PB = pd_bit(k);
    localparam int RA = pr_addr(k);
    localparam int RB = pr_bit(k);
    logic pd_wr, auto_hit;
    assign pd_wr    = wr_en && (wr_addr == 3'(PA));
    assign auto_hit = hw_clr && (hw_idx == IDX_W'(k)) && AUTO_CLR[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        en[k]   <= 1'b0;
        pri[k]  <= '0;
        pend[k] <= 1'b0;
      end else begin
        if (wr_en && wr_addr == 3'(EA)) en[k] <= wr_data[EB];
        if (wr_en && wr_addr == 3'(RA)) pri[k] <= wr_data[RB +: LVL_W];
        pend[k] <= src[k] | (pd_wr ? wr_data[PB] : (auto_hit ? 1'b0 : pend[k]));
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == 3'd0) rd_data[GLOBAL_BIT] = glob;
    for (int k = 0; k < N_SRC; k++) begin
      if (rd_addr == 3'(en_addr(k))) rd_data[en_bit(k)] = en[k];
      if (rd_addr == 3'(pd_addr(k))) rd_data[pd_bit(k)] = pend[k];
      if (rd_addr == 3'(pr_addr(k))) rd_data[pr_bit(k) +: LVL_W] = pri[k];
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  input  lvl_t             pri [N_SRC],
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output lvl_t             lvl
);
  // Scan from the top index down; ">=" lets a lower index take over a tie.
  always_comb begin
    any = 1'b0;
    idx = '0;
    lvl = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (req[k] && (!any || pri[k] >= lvl)) begin
        any = 1'b1;
        idx = IDX_W'(k);
        lvl = pri[k];
      end
    end
  end
endmodule

// File: rtl/intc_nest.sv
module intc_nest
  import intc_pkg::*;
#(
  localparam int DW = $clog2(N_LVL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  lvl_t          push_lvl,
  input  logic          pop,
  output logic          active,
  output lvl_t          top_lvl,
  output logic [DW-1:0] depth
);
  lvl_t stk [N_LVL];
  logic [DW-1:0] below;

  assign below   = depth - DW'(1);
  assign active  = (depth != '0);
  assign top_lvl = active ? stk[below[LVL_W-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= '0;
      for (int i = 0; i < N_LVL; i++) stk[i] <= '0;
    end else if (push && depth < DW'(N_LVL)) begin
      stk[depth[LVL_W-1:0]] <= push_lvl;
      depth <= depth + DW'(1);
    end else if (pop && active) begin
      depth <= below;
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
  parameter logic [N_SRC-1:0] AUTO_CLR = 8'b0000_0101,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int DW = $clog2(N_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic             insn_done_i,
  input  logic             next_multi_i,
  input  logic             ret_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0] pend, en, gate_now, gate_prev, gate_eff;
  logic             glob, win_any, allow, grant;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl, top_lvl;
  lvl_t             pri [N_SRC];
  logic             nest_active;
  logic [DW-1:0]    nest_depth;

  intc_regs #(.N_SRC(N_SRC), .AUTO_CLR(AUTO_CLR)) u_regs (
    .clk(clk), .rst(rst), .src(src_i),
    .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i), .rd_addr(rd_addr_i),
    .hw_clr(grant), .hw_idx(win_idx),
    .pend(pend), .en(en), .glob(glob), .pri(pri), .rd_data(rd_data_o)
  );

  // A cleared enable still counts for one more cycle unless the next
  // instruction is multi-cycle.
  assign gate_now = en & {N_SRC{glob}};
  always_ff @(posedge clk) begin
    if (rst) gate_prev <= '0;
    else     gate_prev <= gate_now;
  end
  assign gate_eff = next_multi_i ? gate_now : (gate_now | gate_prev);

  intc_arb #(.N_SRC(N_SRC)) u_arb (
    .req(pend & gate_eff), .pri(pri), .any(win_any), .idx(win_idx), .lvl(win_lvl)
  );

  assign allow = !nest_active || (win_lvl > top_lvl);
  assign grant = insn_done_i && !ret_i && win_any && allow;

  intc_nest u_nest (
    .clk(clk), .rst(rst), .push(grant), .push_lvl(win_lvl), .pop(ret_i),
    .active(nest_active), .top_lvl(top_lvl), .depth(nest_depth)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      take_o <= grant;
      if (grant) vec_o <= VEC_BASE + (VEC_W'(win_idx) << 3);
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = '0,
  parameter int DW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             insn_done_i,
  input logic             ret_i,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [DW-1:0]    depth
);
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(insn_done_i)); // R5
  AST_VEC_STRIDE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> vec_o[2:0] == VEC_BASE[2:0]); // R5
  AST_NO_TAKE_ON_RETURN: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !$past(ret_i)); // R9
  AST_PUSH_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> depth == $past(depth) + DW'(1)); // R7
  AST_POP_ON_RETURN: assert property (@(posedge clk) disable iff (rst)
    (ret_i && depth != '0) |=> depth == $past(depth) - DW'(1)); // R7
endmodule

bind prio_vec_intc intc_chk #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .insn_done_i(insn_done_i), .ret_i(ret_i),
  .take_o(take_o), .vec_o(vec_o), .depth(nest_depth)
);

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
  localparam int N = 8;
  localparam logic [15:0] BASE = 16'h0003;
  localparam logic [7:0]  AUTO = 8'b0000_0101;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src = '0;
  logic wr_en = 1'b0, insn = 1'b0, multi = 1'b0, ret = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic take;
  logic [15:0] vec;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  prio_vec_intc u0 (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .insn_done_i(insn), .next_multi_i(multi), .ret_i(ret), .take_o(take), .vec_o(vec)
  );

  function automatic logic [15:0] vec_of(int k);
    return BASE + 16'(k * 8);
  endfunction

  // Winner among requests: highest level, lowest index on ties; -1 if none.
  function automatic int pick(logic [7:0] req, logic [15:0] pr);
    int best = -1;
    for (int k = 0; k < N; k++)
      if (req[k] && (best < 0 || pr[2*k +: 2] > pr[2*best +: 2])) best = k;
    return best;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse(logic [7:0] m);
    src = m;
    @(posedge clk); #1;
    src = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  // One boundary cycle; returns what the grant strobe shows after it.
  task automatic bnd(logic m, logic r, logic [7:0] s, output logic t, output logic [15:0] v);
    insn = 1'b1; multi = m; ret = r; src = s;
    @(posedge clk); #1;
    t = take; v = vec;
    insn = 1'b0; multi = 1'b0; ret = 1'b0; src = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic t;
    logic [15:0] v;
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); chk("R1 reg after reset", d, 0);
    end
    bnd(0, 0, 0, t, v); chk("R1 no grant after reset", t, 0);

    // R2: flag sets with everything disabled
    pulse(8'h08); rd(2, d); chk("R2 pending while disabled", d, 8'h08);
    // R4: enable on, global off
    wr(0, 8'h7F); bnd(0, 0, 0, t, v); chk("R4 global off blocks", t, 0);
    // R3: global on, source 3 disabled
    wr(0, 8'h80); bnd(0, 0, 0, t, v); chk("R3 disabled source ignored", t, 0);
    // R5: enabled but no boundary -> quiet
    wr(0, 8'h88);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1; chk("R5 no grant without boundary", take, 0);
    end
    bnd(0, 0, 0, t, v); chk("R5 grant at boundary", t, 1); chk("R5 vector src3", v, vec_of(3));
    @(posedge clk); #1; chk("R5 strobe one cycle", take, 0);
    rd(2, d); chk("R8 non-auto flag kept", d, 8'h08);
    wr(2, 0); bnd(0, 1, 0, t, v); chk("R9 return boundary quiet", t, 0);

    // R6/R3/R12 random arbitration rounds
    for (int it = 0; it < 24; it++) begin
      logic [7:0] em, pm;
      logic [15:0] pr;
      int w;
      em = 8'($urandom); pm = 8'($urandom); pr = 16'($urandom);
      wr(0, {1'b1, em[6:0]}); wr(1, {7'b0, em[7]});
      wr(4, pr[7:0]); wr(5, pr[15:8]);
      rd(5, d); chk("R12 priority readback", d, pr[15:8]);
      rd(0, d); chk("R12 enable readback", d, {1'b1, em[6:0]});
      pulse(pm);
      w = pick(pm & em, pr);
      bnd(0, 0, 0, t, v);
      chk("R6 random grant presence", t, (w >= 0));
      if (w >= 0) chk("R6 random winner vector", v, vec_of(w));
      rd(2, d);
      chk("R8 random pending after grant", d,
          (w >= 0 && AUTO[w]) ? (pm & ~(8'h01 << w)) : pm);
      wr(2, 0);
      if (w >= 0) begin
        bnd(0, 1, 0, t, v); chk("R9 random return quiet", t, 0);
      end
    end

    // R7: nesting. src1 lvl1, src4 lvl1, src5 lvl2
    wr(0, 8'hFF); wr(1, 8'h01); wr(4, 8'h04); wr(5, 8'h09);
    pulse(8'h02); bnd(0, 0, 0, t, v); chk("R7 first grant src1", v, vec_of(1));
    wr(2, 0); pulse(8'h10);
    bnd(0, 0, 0, t, v); chk("R7 equal level no preempt", t, 0);
    pulse(8'h20); bnd(0, 0, 0, t, v);
    chk("R7 higher preempts", t, 1); chk("R7 preempt vector src5", v, vec_of(5));
    wr(2, 8'h10);
    bnd(0, 1, 0, t, v); chk("R9 return from src5 quiet", t, 0);
    bnd(0, 0, 0, t, v); chk("R7 after pop still level1 busy", t, 0);
    bnd(0, 1, 0, t, v); chk("R9 return from src1 quiet", t, 0);
    bnd(0, 0, 0, t, v); chk("R7 empty stack grants src4", v, vec_of(4));
    chk("R7 grant src4 strobe", t, 1);
    wr(2, 0); bnd(0, 1, 0, t, v);

    // R8/R9: auto clear and re-entry
    wr(4, 0); wr(5, 0);
    pulse(8'h09); bnd(0, 0, 0, t, v); chk("R6 tie lowest index", v, vec_of(0));
    rd(2, d); chk("R8 auto-cleared src0 only", d, 8'h08);
    bnd(0, 1, 0, t, v); chk("R9 no grant at return", t, 0);
    bnd(0, 0, 0, t, v); chk("R9 re-entry next boundary", t, 1);
    chk("R9 re-entry vector", v, vec_of(3));
    wr(2, 0); bnd(0, 1, 0, t, v);

    // R11: pulse against clears in the same cycle
    src = 8'h08; wr(2, 0); src = '0;
    rd(2, d); chk("R11 pulse beats software clear", d, 8'h08);
    wr(2, 0); pulse(8'h01);
    bnd(0, 0, 8'h01, t, v); chk("R11 grant src0", v, vec_of(0));
    rd(2, d); chk("R11 pulse beats auto clear", d, 8'h01);
    wr(2, 0); bnd(0, 1, 0, t, v);

    // R10: late enable clear
    wr(4, 0); pulse(8'h08); wr(0, 8'h80);
    bnd(0, 0, 0, t, v); chk("R10 single-cycle next still grants", t, 1);
    wr(2, 0); bnd(0, 1, 0, t, v);
    wr(0, 8'hFF); pulse(8'h08); wr(0, 8'h80);
    bnd(1, 0, 0, t, v); chk("R10 multi-cycle next suppresses", t, 0);
    bnd(0, 0, 0, t, v); chk("R3 cleared enable stays off", t, 0);
    wr(0, 8'hFF); wr(0, 8'h7F);
    bnd(0, 0, 0, t, v); chk("R10 late global clear grants", t, 1);
    bnd(0, 1, 0, t, v); chk("R9 return quiet", t, 0);
    bnd(0, 0, 0, t, v); chk("R4 global off after return", t, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule